// File: doc/BRIEF.md
# Address Translation Fault Recorder

This block sits beside two address translation instances and records the faults they report. Each instance signals faults as one-cycle pulses on seven type lines. With each pulse it also gives the upper bits of the faulting virtual address, the physical address that was found to be invalid, the access direction, the table layer and the fields of the requester that caused the access. The recorder combines the pulses from both instances into one status word. It keeps the details of the first enabled fault per instance and drives one level interrupt line until software clears it.

Software uses a single-cycle register port. Read data is combinational while `reg_en` is high and `reg_we` is low, and writes take effect at the clock edge. A typical handler reads the status word, services instance 0 before instance 1, reads the detail registers of each instance that shows a fault, and then writes the control register with the clear bit set. The clear is done as a read-modify-write so that the other control bits are kept.

Top module: `xfc_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Type t (0 translation, 1 multi-hit, 2 invalid physical address, 3 entry replacement, 4 TLB miss, 5 miss-FIFO, 6 prefetch-FIFO) of instance k sets status bit k*7+t at offset 0x08. The same bit positions are used on `flt_vec`.
- R3: The enable register at offset 0x04 has the same layout as the status word. A fault pulse whose enable bit is 0 sets no status bit, raises no interrupt and does not change the detail registers.
- R4: `irq` is high exactly when some status bit is set. It goes high in the cycle after an enabled fault pulse and stays high until a clear.
- R5: The first enabled fault of an instance with clear status is captured in that instance's detail registers. The address register holds the virtual address with bit 0 = table layer and bit 1 = 1 for a write, and there is a separate physical address register.
- R6: Further faults of an instance with status set OR into its status bits and leave its detail registers unchanged.
- R7: Writing 1 to bit 12 of the control register (offset 0x00) zeroes the status and re-arms capture. Bit 12 reads back 0, and the other written control bits read back as written. The detail registers keep their values.
- R8: The two instances are recorded independently, including when both fault in the same cycle.
- R9: In the default layout the requester register holds the port number in bits [6:2] and the arbiter number in bits [9:7], with all other bits 0. When `ALT_RID`=1, the group number goes to [11:9] and the sub-group to [8:7].
- R10: A fault in the same cycle as a clear write is recorded after the clear, and its details are captured as a first fault.
- R11: The detail registers of instance k are at 0x10+0x10*k (virtual address), +0x04 (physical address) and +0x08 (requester). Reads from unmapped offsets return 0, and writes to the status and detail offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_vec | input | NUM_INST*NT | Fault type pulses, instance k in bits [k*7+6:k*7] |
| flt_va | input | NUM_INST*(AW-2) | Upper virtual address bits [AW-1:2] per instance |
| flt_pa | input | NUM_INST*AW | Invalid physical address per instance |
| flt_wr | input | NUM_INST | 1 for a write access |
| flt_layer | input | NUM_INST | Table layer of the walk |
| flt_port | input | NUM_INST*5 | Requester port number |
| flt_grp | input | NUM_INST*3 | Requester arbiter or group number |
| flt_sub | input | NUM_INST*2 | Requester sub-group (used only in the alternate layout) |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid while reading |
| irq | output | 1 | Level fault interrupt |

## Verification
The hardest case to reach is a fault pulse that arrives in the same cycle as the clear write. In that case the status must first empty and then refill, and a new set of details must be captured. The bench drives fault pulses and the control write together in one cycle, both in a directed step and at random during a long mixed run. The run also toggles the enable mask at random, so that the enable setting changes between faults and some pulses fall on disabled types, checking that these leave the detail registers unchanged.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int unsigned TYPES    = 7;
    localparam int unsigned CLR_BIT  = 12;
    localparam int unsigned OFF_CTRL = 'h00;
    localparam int unsigned OFF_EN   = 'h04;
    localparam int unsigned OFF_STAT = 'h08;
    localparam int unsigned OFF_SLOT = 'h10;
    localparam int unsigned SLOT_STEP = 'h10;
    localparam int unsigned SUB_VA   = 'h0;
    localparam int unsigned SUB_PA   = 'h4;
    localparam int unsigned SUB_RID  = 'h8;

    typedef enum logic [2:0] {
        FT_XLATE   = 3'd0,
        FT_MHIT    = 3'd1,
        FT_BAD_PA  = 3'd2,
        FT_REPLACE = 3'd3,
        FT_MISS    = 3'd4,
        FT_MISSQ   = 3'd5,
        FT_PREFQ   = 3'd6
    } fault_type_e;
endpackage

// File: rtl/xfc_rid_pack.sv
module xfc_rid_pack #(
    parameter int RID_W = 12,
    parameter bit ALT   = 1'b0
) (
    input  logic [4:0]       port_i,
    input  logic [2:0]       grp_i,
    input  logic [1:0]       sub_i,
    output logic [RID_W-1:0] rid_o
);
    generate
        if (ALT) begin : g_alt
            assign rid_o = RID_W'({grp_i, sub_i, port_i, 2'b00});
        end else begin : g_std
            logic unused_sub;
            assign unused_sub = ^sub_i;
            assign rid_o = RID_W'({grp_i, port_i, 2'b00});
        end
    endgenerate
endmodule

// File: rtl/xfc_slot.sv
module xfc_slot #(
    parameter int NT    = 7,
    parameter int AW    = 32,
    parameter int RID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [NT-1:0]    en_i,
    input  logic [NT-1:0]    flt_i,
    input  logic [AW-3:0]    va_hi_i,
    input  logic [AW-1:0]    pa_i,
    input  logic             wr_i,
    input  logic             layer_i,
    input  logic [RID_W-1:0] rid_i,
    output logic [NT-1:0]    status_o,
    output logic [AW-1:0]    va_o,
    output logic [AW-1:0]    pa_o,
    output logic [RID_W-1:0] rid_o
);
    typedef struct packed {
        logic [NT-1:0]    status;
        logic [AW-1:0]    va;
        logic [AW-1:0]    pa;
        logic [RID_W-1:0] rid;
    } slot_s;

    slot_s slot_d, slot_q;
    logic [NT-1:0] base_w, hit_w;

    always_comb begin
        slot_d = slot_q;
        base_w = clr_i ? '0 : slot_q.status;
        hit_w  = flt_i & en_i;
        slot_d.status = base_w | hit_w;
        if (base_w == '0 && hit_w != '0) begin
            slot_d.va  = {va_hi_i, wr_i, layer_i};
            slot_d.pa  = pa_i;
            slot_d.rid = rid_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign status_o = slot_q.status;
    assign va_o     = slot_q.va;
    assign pa_o     = slot_q.pa;
    assign rid_o    = slot_q.rid;
endmodule

// File: rtl/xfc_top.sv
module xfc_top #(
    parameter int NUM_INST = 2,
    parameter int NT       = 7,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int ADDR_W   = 8,
    parameter int RID_W    = 12,
    parameter bit ALT_RID  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_INST*NT-1:0]   flt_vec,
    input  logic [NUM_INST*(AW-2)-1:0] flt_va,
    input  logic [NUM_INST*AW-1:0]   flt_pa,
    input  logic [NUM_INST-1:0]      flt_wr,
    input  logic [NUM_INST-1:0]      flt_layer,
    input  logic [NUM_INST*5-1:0]    flt_port,
    input  logic [NUM_INST*3-1:0]    flt_grp,
    input  logic [NUM_INST*2-1:0]    flt_sub,
    input  logic                     reg_en,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    output logic                     irq
);
    import xfc_pkg::*;

    localparam int SW = NUM_INST * NT;
    localparam logic [DW-1:0] CLR_MASK = DW'(1) << CLR_BIT;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [SW-1:0] en;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic clr_w, wr_ctrl, wr_en;
    logic [SW-1:0]       status_all;
    logic [SW-1:0]       en_q;
    logic [NUM_INST*AW-1:0] va_flat;
    logic [NUM_INST*AW-1:0] pa_flat;
    logic [NUM_INST*RID_W-1:0] rid_flat;

    assign wr_ctrl = reg_en && reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
    assign wr_en   = reg_en && reg_we && (reg_addr == ADDR_W'(OFF_EN));
    assign clr_w   = wr_ctrl && reg_wdata[CLR_BIT];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) cfg_d.ctrl = reg_wdata & ~CLR_MASK;
        if (wr_en)   cfg_d.en   = reg_wdata[SW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_q = cfg_q.en;

    generate
        for (genvar k = 0; k < NUM_INST; k++) begin : g_inst
            logic [RID_W-1:0] rid_w;
            xfc_rid_pack #(.RID_W(RID_W), .ALT(ALT_RID)) u_rid (
                .port_i (flt_port[k*5 +: 5]),
                .grp_i  (flt_grp[k*3 +: 3]),
                .sub_i  (flt_sub[k*2 +: 2]),
                .rid_o  (rid_w)
            );
            xfc_slot #(.NT(NT), .AW(AW), .RID_W(RID_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_i    (clr_w),
                .en_i     (cfg_q.en[k*NT +: NT]),
                .flt_i    (flt_vec[k*NT +: NT]),
                .va_hi_i  (flt_va[k*(AW-2) +: (AW-2)]),
                .pa_i     (flt_pa[k*AW +: AW]),
                .wr_i     (flt_wr[k]),
                .layer_i  (flt_layer[k]),
                .rid_i    (rid_w),
                .status_o (status_all[k*NT +: NT]),
                .va_o     (va_flat[k*AW +: AW]),
                .pa_o     (pa_flat[k*AW +: AW]),
                .rid_o    (rid_flat[k*RID_W +: RID_W])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            if (reg_addr == ADDR_W'(OFF_CTRL)) reg_rdata = cfg_q.ctrl;
            if (reg_addr == ADDR_W'(OFF_EN))   reg_rdata = DW'(cfg_q.en);
            if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata = DW'(status_all);
            for (int k = 0; k < NUM_INST; k++) begin
                if (reg_addr == ADDR_W'(OFF_SLOT + k*SLOT_STEP + SUB_VA))
                    reg_rdata = DW'(va_flat[k*AW +: AW]);
                if (reg_addr == ADDR_W'(OFF_SLOT + k*SLOT_STEP + SUB_PA))
                    reg_rdata = DW'(pa_flat[k*AW +: AW]);
                if (reg_addr == ADDR_W'(OFF_SLOT + k*SLOT_STEP + SUB_RID))
                    reg_rdata = DW'(rid_flat[k*RID_W +: RID_W]);
            end
        end
    end

    assign irq = |status_all;
endmodule

// File: rtl/xfc_chk.sv
module xfc_chk #(
    parameter int NUM_INST = 2,
    parameter int NT       = 7,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int ADDR_W   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_en,
    input logic                   reg_we,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [DW-1:0]          reg_wdata,
    input logic [NUM_INST*NT-1:0] flt_vec,
    input logic                   irq,
    input logic [NUM_INST*NT-1:0] status,
    input logic [NUM_INST*NT-1:0] en,
    input logic [NUM_INST*AW-1:0] va_flat,
    input logic [NUM_INST*AW-1:0] pa_flat
);
    logic clr;
    assign clr = reg_en && reg_we && (reg_addr == ADDR_W'(xfc_pkg::OFF_CTRL))
                 && reg_wdata[xfc_pkg::CLR_BIT];

    // R6
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));

    // R3
    masked_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(en)) == '0));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ((flt_vec & en) == '0)) |=> (status == '0));

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(flt_vec & en)));

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    generate
        for (genvar k = 0; k < NUM_INST; k++) begin : g_hold
            // R6
            detail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (status[k*NT +: NT] != '0 && !clr) |=>
                ($stable(va_flat[k*AW +: AW]) && $stable(pa_flat[k*AW +: AW])));
        end
    endgenerate
endmodule

bind xfc_top xfc_chk #(
    .NUM_INST(NUM_INST), .NT(NT), .AW(AW), .DW(DW), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flt_vec(flt_vec), .irq(irq),
    .status(status_all), .en(en_q), .va_flat(va_flat), .pa_flat(pa_flat)
);

// File: tb/xfc_top_tb.sv
module xfc_top_tb;
    localparam int NI = 2;
    localparam int NT = 7;
    localparam int SW = NI * NT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0]      flt_vec = '0;
    logic [NI*30-1:0]   flt_va = '0;
    logic [NI*32-1:0]   flt_pa = '0;
    logic [NI-1:0]      flt_wr = '0;
    logic [NI-1:0]      flt_layer = '0;
    logic [NI*5-1:0]    flt_port = '0;
    logic [NI*3-1:0]    flt_grp = '0;
    logic [NI*2-1:0]    flt_sub = '0;
    logic               reg_en = 1'b0;
    logic               reg_we = 1'b0;
    logic [7:0]         reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] e_ctrl;
    logic [SW-1:0] e_en, e_stat;
    logic [31:0] e_va [NI];
    logic [31:0] e_pa [NI];
    logic [31:0] e_rid [NI];

    always #4 clk = ~clk;

    xfc_top u_dut (
        .clk(clk), .rst_n(rst_n), .flt_vec(flt_vec), .flt_va(flt_va),
        .flt_pa(flt_pa), .flt_wr(flt_wr), .flt_layer(flt_layer),
        .flt_port(flt_port), .flt_grp(flt_grp), .flt_sub(flt_sub),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rid_of(input logic [2:0] g, input logic [4:0] p);
        return (32'(g) << 7) | (32'(p) << 2);
    endfunction

    // Update the model with what is driven during the edge, then advance.
    task automatic tick();
        logic clr;
        logic [NT-1:0] base, hit;
        @(posedge clk);
        clr = reg_en && reg_we && reg_addr == 8'h00 && reg_wdata[12];
        for (int k = 0; k < NI; k++) begin
            base = clr ? '0 : e_stat[k*NT +: NT];
            hit  = flt_vec[k*NT +: NT] & e_en[k*NT +: NT];
            if (base == '0 && hit != '0) begin
                e_va[k]  = {flt_va[k*30 +: 30], flt_wr[k], flt_layer[k]};
                e_pa[k]  = flt_pa[k*32 +: 32];
                e_rid[k] = rid_of(flt_grp[k*3 +: 3], flt_port[k*5 +: 5]);
            end
            e_stat[k*NT +: NT] = base | hit;
        end
        if (reg_en && reg_we && reg_addr == 8'h00) e_ctrl = reg_wdata & ~32'h1000;
        if (reg_en && reg_we && reg_addr == 8'h04) e_en = reg_wdata[SW-1:0];
        @(negedge clk);
        flt_vec = '0; reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 0;
    endtask

    task automatic set_wr(input logic [7:0] a, input logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic set_flt(input int k, input logic [NT-1:0] v, input logic [31:0] va,
                           input logic [31:0] pa, input bit w, input bit l,
                           input logic [4:0] p, input logic [2:0] g);
        flt_vec[k*NT +: NT] = v;
        flt_va[k*30 +: 30]  = va[31:2];
        flt_pa[k*32 +: 32]  = pa;
        flt_wr[k] = w; flt_layer[k] = l;
        flt_port[k*5 +: 5] = p; flt_grp[k*3 +: 3] = g;
        flt_sub[k*2 +: 2] = 2'(~g);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        rd(8'h08, d); check(d == 32'(e_stat), {tag, " R2 status"}, d, 32'(e_stat));
        check(irq == (e_stat != '0), {tag, " R4 irq"}, 32'(irq), 32'(e_stat != '0));
        for (int k = 0; k < NI; k++) begin
            rd(8'(16 + 16*k), d); check(d == e_va[k], {tag, " R5 va"}, d, e_va[k]);
            rd(8'(20 + 16*k), d); check(d == e_pa[k], {tag, " R5 pa"}, d, e_pa[k]);
            rd(8'(24 + 16*k), d); check(d == e_rid[k], {tag, " R9 rid"}, d, e_rid[k]);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        e_ctrl = '0; e_en = '0; e_stat = '0;
        for (int k = 0; k < NI; k++) begin e_va[k] = '0; e_pa[k] = '0; e_rid[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h04, d); check(d == 0, "R1 enable", d, 0);
        check_all("R1");

        set_wr(8'h04, 32'h3fff); tick();
        rd(8'h04, d); check(d == 32'h3fff, "R3 enable readback", d, 32'h3fff);

        // R2 R5 R9 first fault, instance 0 translation fault, write, layer 0
        set_flt(0, 7'h01, 32'hA000_1234, 32'h8000_0040, 1, 0, 5'd19, 3'd5); tick();
        check_all("first");
        rd(8'h10, d); check(d == 32'hA000_1236, "R5 va flags", d, 32'hA000_1236);
        rd(8'h18, d); check(d == 32'h2CC, "R9 rid layout", d, 32'h2CC);

        // R6 later fault keeps details
        set_flt(0, 7'h10, 32'h1111_2220, 32'h2, 0, 1, 5'd1, 3'd1); tick();
        rd(8'h08, d); check(d == 32'h11, "R6 or status", d, 32'h11);
        check_all("R6");

        // R8 instance 1 prefetch-FIFO -> bit 13
        set_flt(1, 7'h40, 32'hBEEF_0001, 32'h77, 0, 1, 5'd31, 3'd7); tick();
        rd(8'h08, d); check(d == 32'h2011, "R8 inst1 bit13", d, 32'h2011);
        check_all("R8");

        // R11 writes to status/detail offsets ignored; unmapped reads 0
        set_wr(8'h08, 32'h0); tick();
        set_wr(8'h10, 32'hFFFF_FFFF); tick();
        rd(8'h3C, d); check(d == 0, "R11 unmapped", d, 0);
        check_all("R11");

        // R7 clear, other bits kept, bit 12 reads 0
        set_wr(8'h00, 32'h0000_1005); tick();
        rd(8'h00, d); check(d == 32'h5, "R7 ctrl readback", d, 32'h5);
        check(irq == 0, "R7 irq low", 32'(irq), 0);
        check_all("R7");

        // R3 disabled types
        set_wr(8'h04, 32'h3f7e); tick();
        set_flt(0, 7'h01, 32'h5555_0000, 32'h9, 0, 0, 5'd2, 3'd2);
        set_flt(1, 7'h01, 32'h6666_0000, 32'h8, 1, 1, 5'd3, 3'd3); tick();
        check(irq == 0, "R3 no irq", 32'(irq), 0);
        check_all("R3");

        // R8 simultaneous faults both captured
        set_wr(8'h04, 32'h3fff); tick();
        set_flt(0, 7'h04, 32'h1234_5678, 32'hA, 1, 1, 5'd7, 3'd1);
        set_flt(1, 7'h08, 32'h8765_4320, 32'hB, 0, 0, 5'd9, 3'd6); tick();
        check_all("R8 both");

        // R10 fault during clear
        set_wr(8'h00, 32'h0000_1000);
        set_flt(1, 7'h02, 32'hCAFE_0000, 32'hC, 1, 0, 5'd4, 3'd4); tick();
        rd(8'h08, d); check(d == 32'h100, "R10 status", d, 32'h100);
        check_all("R10");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 8);
            if (op == 0) set_wr(8'h04, $urandom);
            else if (op == 1) set_wr(8'h00, $urandom | 32'h1000);
            for (int k = 0; k < NI; k++)
                set_flt(k, 7'($urandom & $urandom & $urandom), $urandom, $urandom,
                        1'($urandom), 1'($urandom), 5'($urandom), 3'($urandom));
            tick();
            check_all("rand");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule